// File: doc/BRIEF.md
# Event Auto-Reset Controller with Veto

This block supervises the per-event reset of a multi-channel front end. A hit from any channel's discriminator opens a decision window of programmable length. Channels whose discriminators fire while the window is open join the same event. When the window runs out without intervention, the block sends a short reset pulse to the time-to-voltage and peak-hold circuits of every channel in the event. The same step clears the event's fast OR and hit count. If the user asserts the veto while the window is open, the reset is withheld and the event is frozen for readout. A later clear request releases it through the same reset pulse.

The fast OR and the hit count are derived from the latched hit set. The count is the digital stand-in for an analog multiplicity level. All pins are plain level or pulse controls. No data is transferred, so there is no valid/ready handshake and back-pressure does not arise. Every output comes straight from a register, so no input reaches an output combinationally.

Top module: `event_autoreset`

## Requirements
- R1: After reset, `chan_rst_o` is all zeros, `fast_or_o` is 0 and `mult_o` is 0.
- R2: A nonzero `hit_i` seen at a clock edge while idle latches those channels. From the next cycle, `fast_or_o` is 1 and `mult_o` equals the number of latched channels.
- R3: Hits arriving while the window is open are added to the event. They do not restart the window timer.
- R4: The window length in cycles is the value of `delay_i` captured at the opening edge, with values below 30 raised to 30. The first reset cycle is that many cycles after the opening edge. Later changes to `delay_i` do not affect an open window.
- R5: When the window expires without a veto, `chan_rst_o` is driven high for exactly 4 cycles. Bit i is set only for channels in the event. During those cycles `fast_or_o` is 0 and `mult_o` is 0.
- R6: A veto sampled while the window is open cancels the reset. No pulse follows, the latched hit set stays unchanged, and new hits are ignored until a clear.
- R7: A clear sampled while an event is held starts the 4-cycle reset pulse on the held channels, beginning in the next cycle, and empties the hit set.
- R8: A veto sampled while idle or during a reset pulse has no effect, and a pulse in progress runs its full 4 cycles. A clear sampled while not holding an event has no effect.
- R9: `mult_o` never exceeds the channel count. With all 32 channels hit it reads 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 10 ns period |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 32 | Per-channel discriminator fire, one bit per channel |
| delay_i | input | 16 | Decision window length in clock cycles (minimum 30 applied) |
| veto_i | input | 1 | User veto; holds the open event instead of resetting it |
| clear_i | input | 1 | Releases a held event through a reset pulse |
| chan_rst_o | output | 32 | Per-channel reset for time-to-voltage and peak-hold circuits |
| fast_or_o | output | 1 | OR of latched channel hits |
| mult_o | output | 6 | Number of latched channel hits, 0 to 32 |

## Verification
The window is opened with a single channel and a delay below the minimum, to show the clamp. A first hit followed later by a pair of hits, with `delay_i` changed mid-window, separates a timer that restarts or re-reads the delay from one that does neither. A veto inside the window, hits arriving while held, and a later clear show the difference between suppression and release. Vetoes and clears outside their valid states confirm they are ignored. An all-channels hit exercises the count at its top value.

// File: rtl/ear_pkg.sv
package ear_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WIN  = 2'd1,
    ST_RST  = 2'd2,
    ST_HOLD = 2'd3
  } ear_state_e;
endpackage

// File: rtl/ear_ctl.sv
module ear_ctl
  import ear_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_DLY = 30,
  parameter int RST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_hit_i,
  input  logic             veto_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] delay_i,
  output ear_state_e       state_o,
  output logic             acc_o,
  output logic             fire_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_DLY);
  localparam logic [CNT_W-1:0] LEN_V = CNT_W'(RST_LEN - 1);

  ear_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] eff_dly;

  assign eff_dly = (delay_i < MIN_V) ? MIN_V : delay_i;
  assign state_o = st_q;

  always_comb begin
    acc_o  = (st_q == ST_IDLE && any_hit_i) || (st_q == ST_WIN);
    fire_o = (st_q == ST_WIN && !veto_i && cnt_q == lim_q - 1'b1) ||
             (st_q == ST_HOLD && clear_i);
    done_o = (st_q == ST_RST) && (cnt_q == LEN_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      lim_q <= MIN_V;
    end else begin
      case (st_q)
        ST_IDLE: if (any_hit_i) begin
          st_q  <= ST_WIN;
          cnt_q <= '0;
          lim_q <= eff_dly;
        end
        ST_WIN: begin
          if (veto_i) begin
            st_q <= ST_HOLD;
          end else if (fire_o) begin
            st_q  <= ST_RST;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RST: begin
          if (done_o) st_q <= ST_IDLE;
          else        cnt_q <= cnt_q + 1'b1;
        end
        ST_HOLD: if (clear_i) begin
          st_q  <= ST_RST;
          cnt_q <= '0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ear_hitreg.sv
module ear_hitreg #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit_i,
  input  logic         acc_i,
  input  logic         fire_i,
  input  logic         done_i,
  output logic [N-1:0] lat_o,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] lat_q, mask_q, lat_nx;

  assign lat_nx = lat_q | (acc_i ? hit_i : '0);
  assign lat_o  = lat_q;
  assign mask_o = mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      mask_q <= '0;
    end else if (fire_i) begin
      mask_q <= lat_nx;
      lat_q  <= '0;
    end else begin
      lat_q <= lat_nx;
      if (done_i) mask_q <= '0;
    end
  end
endmodule

// File: rtl/ear_popcnt.sv
module ear_popcnt #(
  parameter int N  = 32,
  parameter int MW = 6
) (
  input  logic [N-1:0]  vec_i,
  output logic [MW-1:0] cnt_o
);
  logic [MW-1:0] psum [N+1];
  assign psum[0] = '0;
  for (genvar i = 0; i < N; i++) begin : g_sum
    assign psum[i+1] = psum[i] + MW'(vec_i[i]);
  end
  assign cnt_o = psum[N];
endmodule

// File: rtl/event_autoreset.sv
module event_autoreset
  import ear_pkg::*;
#(
  parameter int N       = 32,
  parameter int CNT_W   = 16,
  parameter int MIN_DLY = 30,
  parameter int RST_LEN = 4,
  localparam int MW     = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     hit_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic             veto_i,
  input  logic             clear_i,
  output logic [N-1:0]     chan_rst_o,
  output logic             fast_or_o,
  output logic [MW-1:0]    mult_o
);
  ear_state_e   st;
  logic         acc, fire, done;
  logic [N-1:0] lat;

  ear_ctl #(.CNT_W(CNT_W), .MIN_DLY(MIN_DLY), .RST_LEN(RST_LEN)) u_ctl (
    .clk(clk), .rst_n(rst_n), .any_hit_i(|hit_i), .veto_i(veto_i),
    .clear_i(clear_i), .delay_i(delay_i), .state_o(st),
    .acc_o(acc), .fire_o(fire), .done_o(done)
  );

  ear_hitreg #(.N(N)) u_hits (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .acc_i(acc),
    .fire_i(fire), .done_i(done), .lat_o(lat), .mask_o(chan_rst_o)
  );

  ear_popcnt #(.N(N), .MW(MW)) u_cnt (
    .vec_i(lat), .cnt_o(mult_o)
  );

  assign fast_or_o = |lat;
endmodule

// File: rtl/ear_chk.sv
module ear_chk
  import ear_pkg::*;
#(
  parameter int N       = 32,
  parameter int MW      = 6,
  parameter int RST_LEN = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   hit_i,
  input logic           veto_i,
  input logic           clear_i,
  input ear_state_e     st,
  input logic [N-1:0]   chan_rst_o,
  input logic           fast_or_o,
  input logic [MW-1:0]  mult_o
);
  logic [7:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= '0;
    else if (|chan_rst_o) run_q <= run_q + 1'b1;
    else                  run_q <= '0;
  end

  // R5
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|chan_rst_o) |-> (run_q == 8'(RST_LEN)));

  // R5
  pulse_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_rst_o) |-> (!fast_or_o && mult_o == '0));

  // R5
  pulse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chan_rst_o) && $past(|chan_rst_o)) |-> $stable(chan_rst_o));

  // R2
  or_matches_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_or_o == (mult_o != '0));

  // R9
  mult_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mult_o <= MW'(N));

  // R6
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && !clear_i) |=> (st == ST_HOLD && $stable(mult_o) && chan_rst_o == '0));

  // R8
  idle_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && veto_i && hit_i == '0) |=> (st == ST_IDLE));
endmodule

bind event_autoreset ear_chk #(.N(N), .MW(MW), .RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .veto_i(veto_i), .clear_i(clear_i),
  .st(st), .chan_rst_o(chan_rst_o), .fast_or_o(fast_or_o), .mult_o(mult_o)
);

// File: tb/event_autoreset_bench.sv
module event_autoreset_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] hit_i = '0;
  logic [15:0] delay_i = 16'd30;
  logic        veto_i = 1'b0;
  logic        clear_i = 1'b0;
  logic [31:0] chan_rst_o;
  logic        fast_or_o;
  logic [5:0]  mult_o;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 0;

  always #5 clk = ~clk;

  event_autoreset u_event_autoreset (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .delay_i(delay_i),
    .veto_i(veto_i), .clear_i(clear_i), .chan_rst_o(chan_rst_o),
    .fast_or_o(fast_or_o), .mult_o(mult_o)
  );

  // behavioural reference: 0 idle, 1 window, 2 pulse, 3 held
  int          ms = 0, mcnt = 0, mwin = 30;
  logic [31:0] mlat = '0, mpulse = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mcnt = 0; mlat = '0; mpulse = '0;
    end else begin
      case (ms)
        0: if (hit_i != 0) begin
          mlat = hit_i; mcnt = 0; ms = 1;
          mwin = (delay_i < 30) ? 30 : int'(delay_i);
        end
        1: begin
          mlat = mlat | hit_i;
          if (veto_i) ms = 3;
          else if (mcnt + 1 == mwin) begin
            mpulse = mlat; mlat = '0; ms = 2; mcnt = 0;
          end else mcnt++;
        end
        2: if (mcnt == 3) begin ms = 0; mpulse = '0; end else mcnt++;
        default: if (clear_i) begin mpulse = mlat; mlat = '0; ms = 2; mcnt = 0; end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    chk(chan_rst_o == (ms == 2 ? mpulse : 32'h0), "R5 model chan_rst", int'(chan_rst_o), int'(ms == 2 ? mpulse : 32'h0));
    chk(fast_or_o == (mlat != 0), "R2 model fast_or", int'(fast_or_o), int'(mlat != 0));
    chk(int'(mult_o) == $countones(mlat), "R9 model mult", int'(mult_o), $countones(mlat));
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic hit_wait(input logic [31:0] h, output int k);
    hit_i = h; k = 0;
    do begin tick(); k++; hit_i = '0; end while (chan_rst_o == 0 && k < 70000);
  endtask

  task automatic pulse_len(output int n);
    n = 1;
    while (chan_rst_o != 0 && n < 100) begin tick(); if (chan_rst_o != 0) n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k, n;
    repeat (3) tick();
    chk(chan_rst_o == 0 && !fast_or_o && mult_o == 0, "R1 reset state", int'(mult_o), 0);
    rst_n = 1'b1;
    tick();
    cmp_en = 1;

    // clamp: 5 becomes 30
    delay_i = 16'd5;
    hit_i = 32'h8; tick(); hit_i = '0;
    chk(fast_or_o && mult_o == 1, "R2 single hit latched", int'(mult_o), 1);
    k = 1;
    while (chan_rst_o == 0 && k < 200) begin tick(); k++; end
    chk(k == 31, "R4 clamped window", k, 31);
    chk(chan_rst_o == 32'h8, "R5 pulse channel", int'(chan_rst_o), 8);
    pulse_len(n);
    chk(n == 4, "R5 pulse length", n, 4);
    tick();

    // no restart, delay sampled at start
    delay_i = 16'd40;
    hit_i = 32'h1; tick(); hit_i = '0; k = 1;
    while (chan_rst_o == 0 && k < 300) begin
      if (k == 5) delay_i = 16'd100;
      if (k == 10) hit_i = 32'h8000_0080; else hit_i = '0;
      tick(); k++;
      if (k == 11) chk(mult_o == 3, "R3 late hits join", int'(mult_o), 3);
    end
    hit_i = '0;
    chk(k == 41, "R3 R4 no restart", k, 41);
    chk(chan_rst_o == 32'h8000_0081, "R3 pulse covers event", int'(chan_rst_o), 32'h8000_0081);
    pulse_len(n); tick();

    // veto then clear
    delay_i = 16'd30;
    hit_i = 32'h6; tick(); hit_i = '0;
    repeat (10) tick();
    veto_i = 1'b1; tick(); veto_i = 1'b0;
    hit_i = 32'h200; tick(); hit_i = '0;
    n = 0;
    repeat (60) begin tick(); if (chan_rst_o != 0) n++; end
    chk(n == 0, "R6 no pulse after veto", n, 0);
    chk(mult_o == 2 && fast_or_o, "R6 event held", int'(mult_o), 2);
    clear_i = 1'b1; tick(); clear_i = 1'b0;
    chk(chan_rst_o == 32'h6, "R7 clear releases", int'(chan_rst_o), 6);
    chk(mult_o == 0, "R7 hit set emptied", int'(mult_o), 0);
    pulse_len(n);
    chk(n == 4, "R7 pulse length", n, 4);
    tick();

    // stray veto and clear while idle
    veto_i = 1'b1; tick(); veto_i = 1'b0;
    clear_i = 1'b1; tick(); clear_i = 1'b0;
    tick();
    chk(chan_rst_o == 0 && mult_o == 0, "R8 idle veto/clear ignored", int'(chan_rst_o), 0);
    hit_wait(32'h10, k);
    chk(k == 31, "R8 window unaffected", k, 31);
    veto_i = 1'b1; pulse_len(n); veto_i = 1'b0;
    chk(n == 4, "R8 veto during pulse", n, 4);
    tick();

    // every channel
    hit_i = 32'hFFFF_FFFF; tick(); hit_i = '0;
    chk(mult_o == 32, "R9 full count", int'(mult_o), 32);
    k = 1;
    while (chan_rst_o == 0 && k < 200) begin tick(); k++; end
    chk(chan_rst_o == 32'hFFFF_FFFF, "R5 all channels reset", int'(chan_rst_o), -1);
    repeat (8) tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule